// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Chain

This block places one scan cell between the core logic and each bidirectional pad, and links the cells into a single serial data register for a test access port controller. Each cell has three scan stages that observe the pad input, the core's output value and the core's output enable. It also has two update latches that can take over the pad's output value and output enable. The pad input can only be observed; nothing in the cell drives it.

All strobes and mode selects come from the test access port controller, which runs on the same clock as the chain. In normal operation the pads follow the core directly, so the chain can sample and preload without disturbing the system. In external-test mode the pads are driven from the update latches instead. A separate high-impedance control turns every pad driver off.

Top module: `bscan_pin_chain`

## Requirements
- R1: While rst_n is low, all scan stages and update latches clear to 0. After reset, tdo reads 0, and in external-test mode pad_out and pad_oe read 0.
- R2: When ext_mode is 0 and hiz_force is 0, pad_out equals core_out and pad_oe equals core_oe in the same cycle, whatever the capture, shift and update strobes do (sample/preload use).
- R3: core_in always equals pad_in.
- R4: On a clock edge with cap_en high, each cell loads pad_in, core_out and core_oe into its scan stages in parallel. cap_en takes priority over shift_en, and tdo then shows core_oe[0] as it was at that edge.
- R5: On a clock edge with shift_en high and cap_en low, the chain moves one place toward tdo. The serial order seen at tdo is cell 0 output enable, cell 0 output, cell 0 input, then cell 1 in the same order, and so on up to the highest cell. tdi enters the input stage of the highest cell.
- R6: The chain is 3 x NUM_PINS stages long. A bit applied at tdi appears at tdo after exactly that many shift edges.
- R7: On a clock edge with upd_en high, each cell's output latch loads the cell's output scan stage and its enable latch loads the enable scan stage, using the values held before that edge. The latches keep their value at every other edge, so shifting and capturing do not change the pads in external-test mode.
- R8: When ext_mode is 1, pad_out comes from the output latch and pad_oe comes from the enable latch (unless R9 applies).
- R9: When hiz_force is 1, every pad_oe bit is 0 in any mode. pad_out still follows the mode selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| ext_mode | input | 1 | 1: pads driven from update latches |
| hiz_force | input | 1 | 1: all pad drivers disabled |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (registered) |
| core_out | input | NUM_PINS | Output values from the core |
| core_oe | input | NUM_PINS | Output enables from the core (1 = drive) |
| pad_in | input | NUM_PINS | Values received at the pads |
| pad_out | output | NUM_PINS | Output values to the pads |
| pad_oe | output | NUM_PINS | Output enables to the pads |
| core_in | output | NUM_PINS | Pad values forwarded to the core |

## Verification
The pad_out, pad_oe and core_in outputs are combinational. The bench checks them about 1 ns after it drives new inputs at the falling edge, in the same cycle. tdo and the update latches are registered and take effect one edge after the strobe. The bench updates its own chain model at the rising edge and compares tdo and the latched pad values at the following falling edge. The 3 x NUM_PINS shift latency is counted edge by edge in a directed walk through the full chain.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   localparam int STAGES_PER_PIN = 3;
   localparam int OE_POS  = 0;   // nearest tdo, leaves first
   localparam int OUT_POS = 1;
   localparam int IN_POS  = 2;

   typedef struct packed {
      logic dat;
      logic oe;
   } pin_drive_t;
endpackage

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
   import bscan_pkg::*;
(
   input  logic       ext_mode,
   input  logic       hiz_force,
   input  logic       core_out,
   input  logic       core_oe,
   input  pin_drive_t latched,
   output logic       pad_out,
   output logic       pad_oe
);
   always_comb begin
      pad_out = ext_mode ? latched.dat : core_out;
      pad_oe  = ext_mode ? latched.oe  : core_oe;
      if (hiz_force) pad_oe = 1'b0;
   end
endmodule

// File: rtl/bscan_io_cell.sv
module bscan_io_cell
   import bscan_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic upd_en,
   input  logic ext_mode,
   input  logic hiz_force,
   input  logic scan_in,
   output logic scan_out,
   input  logic core_out,
   input  logic core_oe,
   input  logic pad_in,
   output logic pad_out,
   output logic pad_oe,
   output logic core_in
);
   logic [STAGES_PER_PIN-1:0] stg_q;
   logic [STAGES_PER_PIN-1:0] cap_val;
   pin_drive_t                latch_q;

   always_comb begin
      cap_val          = '0;
      cap_val[OE_POS]  = core_oe;
      cap_val[OUT_POS] = core_out;
      cap_val[IN_POS]  = pad_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stg_q <= '0;
      else if (cap_en)    stg_q <= cap_val;
      else if (shift_en)  stg_q <= {scan_in, stg_q[STAGES_PER_PIN-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '0;
      else if (upd_en) latch_q <= '{dat: stg_q[OUT_POS], oe: stg_q[OE_POS]};
   end

   assign scan_out = stg_q[OE_POS];
   assign core_in  = pad_in;

   bscan_pad_mux u_mux (
      .ext_mode  (ext_mode),
      .hiz_force (hiz_force),
      .core_out  (core_out),
      .core_oe   (core_oe),
      .latched   (latch_q),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );
endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
   import bscan_pkg::*;
#(
   parameter int NUM_PINS = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic                shift_en,
   input  logic                upd_en,
   input  logic                ext_mode,
   input  logic                hiz_force,
   input  logic                tdi,
   output logic                tdo,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] core_in
);
   localparam int CHAIN_LEN = NUM_PINS * STAGES_PER_PIN;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("bscan_pin_chain: NUM_PINS must be at least 1");
   end
   if (CHAIN_LEN > 3072) begin : g_bad_len
      $error("bscan_pin_chain: chain of %0d stages is too long", CHAIN_LEN);
   end

   logic [NUM_PINS:0] link;
   assign link[NUM_PINS] = tdi;
   assign tdo            = link[0];

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
      bscan_io_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap_en    (cap_en),
         .shift_en  (shift_en),
         .upd_en    (upd_en),
         .ext_mode  (ext_mode),
         .hiz_force (hiz_force),
         .scan_in   (link[k+1]),
         .scan_out  (link[k]),
         .core_out  (core_out[k]),
         .core_oe   (core_oe[k]),
         .pad_in    (pad_in[k]),
         .pad_out   (pad_out[k]),
         .pad_oe    (pad_oe[k]),
         .core_in   (core_in[k])
      );
   end
endmodule

// File: rtl/bscan_pin_chain_chk.sv
module bscan_pin_chain_chk #(
   parameter int NUM_PINS = 4
)(
   input logic                clk,
   input logic                rst_n,
   input logic                cap_en,
   input logic                shift_en,
   input logic                upd_en,
   input logic                ext_mode,
   input logic                hiz_force,
   input logic                tdi,
   input logic                tdo,
   input logic [NUM_PINS-1:0] core_out,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] core_in
);
   AST_HIZ_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_force |-> pad_oe == '0); // R9

   AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && !hiz_force) |-> (pad_out == core_out && pad_oe == core_oe)); // R2

   AST_CAPTURE_TDO: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> tdo == $past(core_oe[0])); // R4

   AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && $past(ext_mode) && !$past(upd_en) && $past(rst_n)) |-> $stable(pad_out)); // R7
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/bscan_pin_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_pin_chain_tb_top;
   localparam int NP = 4;
   localparam int L  = 3 * NP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_en = 0, shift_en = 0, upd_en = 0, ext_mode = 0, hiz_force = 0, tdi = 0;
   logic tdo;
   logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, core_in;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [L-1:0]  m_chain = '0;
   logic [NP-1:0] m_dat = '0, m_oe = '0;

   always #5 clk = ~clk;

   bscan_pin_chain #(.NUM_PINS(NP)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] exp_out();
      return ext_mode ? m_dat : core_out;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      if (hiz_force) return '0;
      return ext_mode ? m_oe : core_oe;
   endfunction

   task automatic check_now();
      string rq;
      rq = hiz_force ? "R9" : (ext_mode ? "R8" : "R2");
      chk(pad_out == exp_out(), {rq, " pad_out"}, 32'(pad_out), 32'(exp_out()));
      chk(pad_oe == exp_oe(), {rq, " pad_oe"}, 32'(pad_oe), 32'(exp_oe()));
      chk(core_in == pad_in, "R3 core_in", 32'(core_in), 32'(pad_in));
      chk(tdo == m_chain[0], "R5 tdo", 32'(tdo), 32'(m_chain[0]));
   endtask

   // model update at the rising edge, then wait for the falling edge
   task automatic tick();
      @(posedge clk);
      if (upd_en) begin
         for (int k = 0; k < NP; k++) begin
            m_dat[k] = m_chain[3*k+1];
            m_oe[k]  = m_chain[3*k];
         end
      end
      if (cap_en) begin
         for (int k = 0; k < NP; k++) begin
            m_chain[3*k]   = core_oe[k];
            m_chain[3*k+1] = core_out[k];
            m_chain[3*k+2] = pad_in[k];
         end
      end else if (shift_en) begin
         m_chain = {tdi, m_chain[L-1:1]};
      end
      @(negedge clk);
   endtask

   initial begin
      logic [L-1:0] word;
      logic [NP-1:0] held_o, held_e;
      void'($urandom(32'h5eed_0042));
      repeat (2) @(negedge clk);
      // R1: reset state
      ext_mode = 1;
      #1;
      chk(tdo == 0, "R1 tdo", 32'(tdo), 0);
      chk(pad_out == 0, "R1 pad_out", 32'(pad_out), 0);
      chk(pad_oe == 0, "R1 pad_oe", 32'(pad_oe), 0);
      rst_n = 1;
      ext_mode = 0;
      @(negedge clk);

      // R6: walk a known word through the whole chain
      word = L'(36'h9_A5C3_6E1B);
      shift_en = 1;
      for (int i = 0; i < L; i++) begin
         tdi = word[i];
         #1; check_now();
         tick();
      end
      tdi = 0;
      for (int i = 0; i < L; i++) begin
         #1;
         chk(tdo == word[i], "R6 shift-through", 32'(tdo), 32'(word[i]));
         tick();
      end
      shift_en = 0;

      // R4/R5: capture with shift also high, then read back the order
      core_oe = 4'b0101; core_out = 4'b0011; pad_in = 4'b1001;
      cap_en = 1; shift_en = 1;
      #1; tick();
      cap_en = 0;
      #1;
      chk(tdo == 1'b1, "R4 capture priority", 32'(tdo), 1);
      for (int i = 0; i < L; i++) begin
         logic e;
         case (i % 3)
            0: e = core_oe[i/3];
            1: e = core_out[i/3];
            default: e = pad_in[i/3];
         endcase
         chk(tdo == e, "R5 bit order", 32'(tdo), 32'(e));
         tick(); #1;
      end
      shift_en = 0;

      // R7/R8: load latches, then shift and capture without update
      m_chain = m_chain; // model already tracks the chain
      shift_en = 1;
      for (int i = 0; i < L; i++) begin tdi = i[0] ^ i[2]; #1; tick(); end
      shift_en = 0; upd_en = 1; ext_mode = 1;
      #1; tick(); upd_en = 0;
      #1; check_now();
      held_o = pad_out; held_e = pad_oe;
      shift_en = 1; tdi = 1;
      repeat (5) begin #1; tick(); end
      cap_en = 1; #1; tick(); cap_en = 0; shift_en = 0;
      #1;
      chk(pad_out == held_o, "R7 hold out", 32'(pad_out), 32'(held_o));
      chk(pad_oe == held_e, "R7 hold oe", 32'(pad_oe), 32'(held_e));
      hiz_force = 1; #1;
      chk(pad_oe == 0, "R9 hiz in extest", 32'(pad_oe), 0);
      chk(pad_out == held_o, "R9 out kept", 32'(pad_out), 32'(held_o));
      hiz_force = 0;

      // random mix
      for (int i = 0; i < 400; i++) begin
         cap_en    = ($urandom % 8) == 0;
         shift_en  = ($urandom % 4) != 0;
         upd_en    = ($urandom % 6) == 0;
         ext_mode  = ($urandom % 2) == 0;
         hiz_force = ($urandom % 7) == 0;
         tdi       = $urandom % 2;
         core_out  = NP'($urandom);
         core_oe   = NP'($urandom);
         pad_in    = NP'($urandom);
         #1; check_now();
         tick();
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(10 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule